// File: doc/BRIEF.md
# Adaptive Fractional Read-Clock Divider

The block produces the smoothed read clock for an elastic buffer that absorbs line jitter. A local reference runs at four times the line rate. The read clock is nominally that reference divided by four. The block itself runs from a clock at twice the reference frequency, so every divide ratio, whole or half, is a whole number of internal ticks. A nominal output period is eight ticks. The average input clock period must stay within ±200 ppm of the reference divided by four, so the nominal ratio carries the long-term rate.

When the buffer nears a limit, the divider reacts period by period. If the buffer is close to full, a period lasts seven ticks (ratio 3.5), which speeds up reads. If the buffer is close to empty, a period lasts nine ticks (ratio 4.5), which slows reads down. This lets the read side follow short-term frequency swings without losing data. The ratio is picked when a period begins and is held until it ends. The high phase is always four ticks long, and the low phase takes up the rest.

The block issues one read-enable pulse per period and also outputs a copy of the reference. A test mode pins the ratio at four. A bypass mode passes the raw line clock straight through to the read-clock output.

Top module: `frac_read_divider`

## Requirements
- R1: With no limit flag set, each read-clock period lasts 8 internal ticks.
- R2: When near_full alone is sampled at a period start, that period lasts 7 ticks.
- R3: When near_empty alone is sampled at a period start, that period lasts 9 ticks.
- R4: If near_full and near_empty are both high at a period start, the period lasts 8 ticks.
- R5: The flags are sampled only on the tick where a period ends. A flag pulse that rises and falls inside a period has no effect on the next period's length.
- R6: In every period the read clock is high for exactly 4 ticks, starting on the period's first tick.
- R7: rd_en is high for exactly one tick per period, on the tick where rd_clk rises.
- R8: ref_out inverts on every internal tick, giving a copy of the 4x reference.
- R9: While test_mode is high, the flags are ignored and every period lasts 8 ticks.
- R10: While bypass is high, rd_clk equals line_clk and rd_en is low.
- R11: While reset is active, rd_clk, rd_en and ref_out are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the reference frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| near_full | input | 1 | Buffer close to full; asks for a shorter period |
| near_empty | input | 1 | Buffer close to empty; asks for a longer period |
| bypass | input | 1 | Pass line_clk through and suppress rd_en |
| test_mode | input | 1 | Hold the ratio at nominal |
| line_clk | input | 1 | Raw line clock used in bypass |
| rd_clk | output | 1 | Read clock |
| rd_en | output | 1 | One-tick read strobe per period |
| ref_out | output | 1 | Copy of the 4x reference |

## Verification
The embedded assertions check the following on every cycle:
- The stored period length is one of the three legal values.
- The length does not change during a period.
- ref_out toggles on every tick.
- rd_en is low in bypass.
- rd_en coincides with a rising read clock.
- Conflicting flags select the nominal length.

Only the bench scenarios can show the actual tick count of each period under each flag pattern, that a flag pulse inside a period is ignored, the effect of test mode, and the line-clock passthrough in bypass.

// File: rtl/frac_read_divider.sv
module frac_read_divider #(
  parameter int NOM_TICKS  = 8,
  parameter int HIGH_TICKS = 4,
  localparam int CW = $clog2(NOM_TICKS + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic near_full,
  input  logic near_empty,
  input  logic bypass,
  input  logic test_mode,
  input  logic line_clk,
  output logic rd_clk,
  output logic rd_en,
  output logic ref_out
);

  localparam logic [CW-1:0] LAST_NOM  = CW'(NOM_TICKS - 1);
  localparam logic [CW-1:0] LAST_FAST = CW'(NOM_TICKS - 2);
  localparam logic [CW-1:0] LAST_SLOW = CW'(NOM_TICKS);

  logic [CW-1:0] cnt, last, next_last;
  logic speed_up, slow_down, div_clk, wrap;

  assign speed_up  = near_full & ~near_empty & ~test_mode;
  assign slow_down = near_empty & ~near_full & ~test_mode;
  assign wrap      = (cnt == last);

  always_comb begin
    next_last = LAST_NOM;
    if (speed_up)       next_last = LAST_FAST;
    else if (slow_down) next_last = LAST_SLOW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= LAST_NOM;
      last    <= LAST_NOM;
      ref_out <= 1'b0;
    end else begin
      ref_out <= ~ref_out;
      if (wrap) begin
        cnt  <= '0;
        last <= next_last;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign div_clk = (cnt < CW'(HIGH_TICKS));
  assign rd_clk  = bypass ? line_clk : div_clk;
  assign rd_en   = ~bypass & (cnt == '0);

  // R1 R2 R3: only legal lengths
  p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last == LAST_NOM) || (last == LAST_FAST) || (last == LAST_SLOW));

  // R5: length held through a period
  p_len_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(last));

  // R4: conflicting flags give nominal
  p_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && near_full && near_empty) |=> (last == LAST_NOM));

  // R7: strobe aligned with rising read clock
  p_strobe_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_clk && $past(!div_clk)));

  // R8: reference copy toggles each tick
  p_ref_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_out != $past(ref_out)));

  // R10: no strobe in bypass
  p_bypass_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !rd_en);

endmodule

// File: tb/tb_frac_read_divider.sv
module tb_frac_read_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic near_full = 0, near_empty = 0, bypass = 0, test_mode = 0, line_clk = 0;
  logic rd_clk, rd_en, ref_out;

  frac_read_divider dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int exp_q[$];
  bit mon_on = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(bit nf, bit ne, bit tm);
    if (tm) return 8;
    if (nf && !ne) return 7;
    if (ne && !nf) return 9;
    return 8;
  endfunction

  // monitor
  int ticks = 0, highs = 0;
  bit seen = 0, ref_prev = 0, ref_bad = 0;
  always @(negedge clk) if (mon_on) begin
    if (ref_out == ref_prev) ref_bad = 1;
    ref_prev = ref_out;
    if (rd_en) begin
      if (seen) begin
        int e;
        e = exp_q.pop_front();
        chk(ticks == e, "R1/R2/R3/R4/R5/R9 period", ticks, e);
        chk(highs == 4, "R6 high phase", highs, 4);
        chk(!ref_bad, "R8 ref toggle", ref_bad, 0);
      end
      chk(rd_clk == 1'b1, "R7 strobe on rise", rd_clk, 1);
      seen = 1; ticks = 1; highs = 1; ref_bad = 0;
    end else begin
      ticks++;
      highs += rd_clk;
    end
  end

  task automatic next_start();
    @(negedge clk);
    while (!rd_en) @(negedge clk);
  endtask

  task automatic drive(input bit nf, input bit ne, input bit tm, input int n);
    for (int i = 0; i < n; i++) begin
      next_start();
      near_full = nf; near_empty = ne; test_mode = tm;
      exp_q.push_back(exp_len(nf, ne, tm));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_clk && !rd_en && !ref_out, "R11 reset state",
        {rd_clk, rd_en, ref_out}, 0);
    exp_q.push_back(8);
    @(negedge clk);
    mon_on = 1; ref_prev = ref_out;
    rst_n = 1;
    drive(0, 0, 0, 3);  // R1
    drive(1, 0, 0, 3);  // R2
    drive(0, 1, 0, 3);  // R3
    drive(1, 1, 0, 2);  // R4
    drive(1, 0, 1, 2);  // R9
    drive(0, 1, 1, 2);  // R9
    drive(0, 1, 0, 1);
    drive(1, 0, 0, 1);
    drive(0, 0, 0, 1);
    // R5: pulse inside the period
    next_start();
    near_full = 0; near_empty = 0; test_mode = 0;
    exp_q.push_back(8);
    repeat (2) @(negedge clk);
    near_full = 1;
    @(negedge clk);
    near_full = 0;
    drive(0, 0, 0, 2);
    next_start();
    next_start();
    mon_on = 0;
    // R10 bypass
    bypass = 1;
    for (int i = 0; i < 24; i++) begin
      line_clk = (i % 3) == 0;
      @(negedge clk);
      if (i % 6 == 0) chk(rd_clk == line_clk, "R10 passthrough", rd_clk, line_clk);
      if (rd_en) chk(0, "R10 strobe low", rd_en, 0);
    end
    chk(rd_en == 0, "R10 strobe low", rd_en, 0);
    done = 1;
  end

  initial begin
    int c = 0;
    while (!done && c < 100000) begin
      @(posedge clk);
      c++;
    end
    if (!done) chk(0, "watchdog", c, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule